// File: doc/BRIEF.md
# Display Layer Stacking Reorder

This block sits in a video pipeline just ahead of the layer mixer. For each pixel it receives one value per display layer, in natural order, and presents the same values in a rearranged stacking order. Layers are organised as groups of four. A 2-bit horizontal control changes the order of the layers inside every group in the same way. A vertical control, one bit per group-number bit, changes the order of the groups themselves.

The remap XORs the combined control word into the layer index. Output slot `i` carries input layer `i ^ {vertical, horizontal}`. With a handful of control bits this can swap neighbours, swap pairs of pairs or reverse a group, and it applies the matching operations between groups. The result is always a permutation of the layers. The controls are captured only on the frame-start strobe, so the order cannot change partway through a frame. The result leaves through a single register stage, and a valid flag follows it with the same latency.

Top module: `layer_order_xor`

## Requirements
- R1: After synchronous active-low reset, `pix_valid_out` is 0, every slot of `layers_out` is 0, and the active control word is zero, so the first pixel after reset passes through in natural order.
- R2: `pix_valid_out` equals `pix_valid_in` delayed by exactly one clock. A pixel presented with valid high appears on `layers_out` one clock later.
- R3: When the active horizontal and vertical values are both 0, output slot k equals input layer k for every k. Layer k occupies bits `[k*PIX_W +: PIX_W]` on both buses.
- R4: Horizontal value 1 exchanges layers 0 and 1, and layers 2 and 3, inside every group of four.
- R5: Horizontal value 2 exchanges the pair of layers 0 and 1 with the pair of layers 2 and 3 inside every group of four.
- R6: Horizontal value 3 reverses the four layers of every group. Slot 4g+j carries layer 4g+(3-j).
- R7: A vertical value v maps output group g to input group g XOR v. The layer position inside the group is unchanged when the horizontal value is 0.
- R8: With both controls non-zero, output slot i carries input layer i XOR (v*4 + h). Every layer appears exactly once.
- R9: The horizontal and vertical inputs are captured only on a clock edge where `frame_start` is 1. Changes to them at any other time have no effect on the ordering.
- R10: While `pix_valid_in` is 0, `layers_out` keeps the last pixel that was output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Start-of-frame strobe; loads the ordering controls |
| hswap_in | input | 2 | Order control inside each group of four |
| vswap_in | input | V_BITS | Order control between groups |
| pix_valid_in | input | 1 | Input pixel valid |
| layers_in | input | N_LAYERS*PIX_W | Layer values in natural order, layer k at `[k*PIX_W +: PIX_W]` |
| pix_valid_out | output | 1 | Output pixel valid, one clock after input |
| layers_out | output | N_LAYERS*PIX_W | Reordered layer values, slot k at `[k*PIX_W +: PIX_W]` |

## Verification
Each layer is given a value whose low nibble is its own index and whose high nibble tags the pixel. A misrouted slot therefore shows exactly which layer arrived, and a stale pixel shows up as a wrong tag. The bench tries every horizontal value with the vertical value at zero, which separates the swap of neighbours from the swap of pairs and from the reversal. It then tries every vertical value with the horizontal value at zero, which isolates the group remap. Two mixed settings show that the two controls combine as a single XOR and are not applied in sequence. Finally, the bench changes the control inputs without a frame strobe and holds valid low, to separate correct frame-locked capture and data hold from a design that follows its inputs directly.

// File: rtl/layer_order_pkg.sv
// Shared constants and helpers for the layer reorder block.
// Assumes groups of exactly four layers, so the in-group index is two bits.
package layer_order_pkg;
    localparam int GRP_BITS = 2;

    // Source layer index for a given output slot under a control word.
    function automatic int unsigned src_layer(int unsigned slot, int unsigned sel);
        return slot ^ sel;
    endfunction
endpackage

// File: rtl/lor_ctrl_latch.sv
// Holds the active ordering control word. It loads {vertical, horizontal}
// only on a frame-start strobe, so the ordering is constant within a frame.
// Assumes frame_start is synchronous to clk.
module lor_ctrl_latch #(
    parameter int V_BITS = 2,
    localparam int SEL_W = V_BITS + layer_order_pkg::GRP_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [1:0]        h_in,
    input  logic [V_BITS-1:0] v_in,
    output logic [SEL_W-1:0]  sel_q
);
    // Capture the control word at frame start; clear to identity on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (frame_start)
            sel_q <= {v_in, h_in};
    end

    // R9: the control word never moves without a frame strobe
    assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(sel_q));

    // R9: a frame strobe loads exactly the presented controls
    assert_ctrl_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (sel_q == $past({v_in, h_in})));
endmodule

// File: rtl/lor_slot_mux.sv
// One output slot: selects input layer (SLOT ^ sel) and registers it
// when a valid pixel is loaded. It holds its value otherwise.
// Assumes sel is stable for the duration of a frame.
module lor_slot_mux #(
    parameter int PIX_W    = 8,
    parameter int N_LAYERS = 16,
    parameter int SEL_W    = 4,
    parameter int SLOT     = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [SEL_W-1:0]          sel,
    input  logic [N_LAYERS*PIX_W-1:0] layers_in,
    output logic [PIX_W-1:0]          pix_q
);
    logic [SEL_W-1:0] src;
    logic [PIX_W-1:0] pick;

    // Compute the source layer index and pick its pixel.
    always_comb begin
        src  = SEL_W'(SLOT) ^ sel;
        pick = layers_in[int'(src)*PIX_W +: PIX_W];
    end

    // Output register: load on valid pixel, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_q <= '0;
        else if (load)
            pix_q <= pick;
    end

    // R10: a slot keeps its value while no pixel is loaded
    assert_slot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(pix_q));
endmodule

// File: rtl/layer_order_xor.sv
// Display layer stacking reorder. Output slot i carries input layer
// i ^ {vertical, horizontal}. The controls are latched at frame start,
// and there is one register stage with a matching valid flag.
// Assumes N_LAYERS = 4 * 2**V_BITS, layer k at bits [k*PIX_W +: PIX_W].
module layer_order_xor #(
    parameter int PIX_W  = 8,
    parameter int V_BITS = 2,
    localparam int SEL_W    = V_BITS + layer_order_pkg::GRP_BITS,
    localparam int N_LAYERS = 1 << SEL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic [1:0]                hswap_in,
    input  logic [V_BITS-1:0]         vswap_in,
    input  logic                      pix_valid_in,
    input  logic [N_LAYERS*PIX_W-1:0] layers_in,
    output logic                      pix_valid_out,
    output logic [N_LAYERS*PIX_W-1:0] layers_out
);
    logic [SEL_W-1:0] sel;

    lor_ctrl_latch #(.V_BITS(V_BITS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .h_in        (hswap_in),
        .v_in        (vswap_in),
        .sel_q       (sel)
    );

    for (genvar s = 0; s < N_LAYERS; s++) begin : g_slot
        lor_slot_mux #(
            .PIX_W(PIX_W), .N_LAYERS(N_LAYERS), .SEL_W(SEL_W), .SLOT(s)
        ) u_mux (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (pix_valid_in),
            .sel       (sel),
            .layers_in (layers_in),
            .pix_q     (layers_out[s*PIX_W +: PIX_W])
        );
    end

    // Valid flag pipeline matching the data register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_valid_out <= 1'b0;
        else
            pix_valid_out <= pix_valid_in;
    end

    // R2: valid in produces valid out one clock later
    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_in |=> pix_valid_out);
    // R2: no valid in means no valid out one clock later
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_in |=> !pix_valid_out);
    // R3: zero controls pass the pixel through unchanged
    assert_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_in && sel == '0) |=> (layers_out == $past(layers_in)));
endmodule

// File: tb/sim_layer_order_xor.sv
module sim_layer_order_xor;
    localparam int PIX_W  = 8;
    localparam int V_BITS = 2;
    localparam int SEL_W  = V_BITS + 2;
    localparam int N      = 1 << SEL_W;
    localparam int BUS_W  = N * PIX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic [1:0]        hswap_in = '0;
    logic [V_BITS-1:0] vswap_in = '0;
    logic              pix_valid_in = 1'b0;
    logic [BUS_W-1:0]  layers_in = '0;
    logic              pix_valid_out;
    logic [BUS_W-1:0]  layers_out;

    int n_tests = 0;
    int n_fail  = 0;
    int model_sel = 0;
    logic [BUS_W-1:0] exp_q[$];
    string            tag_q[$];
    logic [BUS_W-1:0] last_out = '0;
    bit               have_last = 1'b0;

    always #5 clk = ~clk;

    layer_order_xor #(.PIX_W(PIX_W), .V_BITS(V_BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .hswap_in(hswap_in), .vswap_in(vswap_in),
        .pix_valid_in(pix_valid_in), .layers_in(layers_in),
        .pix_valid_out(pix_valid_out), .layers_out(layers_out)
    );

    // Layer k gets value {tag nibble, k}.
    function automatic logic [BUS_W-1:0] make_pix(int seed);
        logic [BUS_W-1:0] v;
        for (int k = 0; k < N; k++)
            v[k*PIX_W +: PIX_W] = PIX_W'(((seed & 15) << 4) | k);
        return v;
    endfunction

    function automatic logic [BUS_W-1:0] remap(logic [BUS_W-1:0] p, int sel);
        logic [BUS_W-1:0] o;
        for (int i = 0; i < N; i++)
            o[i*PIX_W +: PIX_W] = p[(i ^ sel)*PIX_W +: PIX_W];
        return o;
    endfunction

    task automatic check(string tag, logic [BUS_W-1:0] got, logic [BUS_W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send(int seed, string tag);
        @(posedge clk); #1;
        pix_valid_in = 1'b1;
        layers_in    = make_pix(seed);
        exp_q.push_back(remap(make_pix(seed), model_sel));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int cycles, int seed);
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk); #1;
            pix_valid_in = 1'b0;
            layers_in    = make_pix(seed + c);
        end
    endtask

    task automatic frame(int h, int v);
        @(posedge clk); #1;
        pix_valid_in = 1'b0;
        frame_start  = 1'b1;
        hswap_in     = 2'(h);
        vswap_in     = V_BITS'(v);
        model_sel    = (v << 2) | h;
        @(posedge clk); #1;
        frame_start  = 1'b0;
    endtask

    // Monitor: compare outputs against the scoreboard away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pix_valid_out) begin
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R2: unexpected valid, got %h expected none", layers_out);
                end else begin
                    check(tag_q.pop_front(), layers_out, exp_q.pop_front());
                end
                last_out  = layers_out;
                have_last = 1'b1;
            end else if (have_last) begin
                check("R10", layers_out, last_out);
            end
        end
    end

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state of outputs
        n_tests++;
        if (pix_valid_out !== 1'b0 || layers_out !== '0) begin
            n_fail++;
            $display("FAIL R1: got valid=%b data=%h expected 0/0", pix_valid_out, layers_out);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        send(1, "R1");          // controls reset to identity
        send(2, "R3");
        idle(2, 9);
        frame(1, 0); send(3, "R4"); send(4, "R4");
        frame(2, 0); send(5, "R5");
        frame(3, 0); send(6, "R6"); send(7, "R6");
        frame(0, 1); send(8, "R7");
        frame(0, 2); send(9, "R7");
        frame(0, 3); send(10, "R7");
        frame(2, 1); send(11, "R8");
        frame(3, 3); send(12, "R8");
        // R9: controls change without a frame strobe
        @(posedge clk); #1;
        pix_valid_in = 1'b0;
        hswap_in = 2'd1; vswap_in = V_BITS'(2);
        send(13, "R9"); send(14, "R9");
        // R10: hold while valid low with changing input data
        idle(4, 3);
        frame(0, 0); send(15, "R3");
        send(2, "R2");
        idle(3, 5);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R2: got %0d pending items expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule